// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps the per-line state of a bank of external interrupt lines. Each line has three state bits: an enable, a sticky pending latch and an active flag. Software changes enable and pending through mask ports. On a mask port a one bit acts on its line and a zero bit leaves that line alone. Each state has a separate set mask and a separate clear mask.

The hardware request lines arrive asynchronously. Each one passes through a two-flop synchronizer. A rising edge of the synchronized level latches the line's pending bit. The controller signals handler entry with an acknowledge carrying the line number. It signals handler exit with a return carrying the line number. A software trigger port pends a single line selected by its number.

The block drives a candidate vector for a downstream priority resolver. A line is a candidate when it is pending and enabled and not active. The enable, pending and active vectors are also driven, so software can read back the current state. All outputs come straight from registers.

Top module: `irq_pend_tracker`

## Requirements
- R1: A one bit in `en_set_mask` sets that line's enable bit, and a one bit in `en_clr_mask` clears it. A zero bit leaves the line's enable unchanged. When both masks carry a one for the same bit in the same cycle, the enable bit ends up cleared. The new value appears on `enable_vec` after one clock edge.
- R2: A one bit in `pend_set_mask` sets that line's pending bit, and a one bit in `pend_clr_mask` clears it. A zero bit has no effect. When both masks carry a one for the same bit in the same cycle, the clear wins. The new value appears after one clock edge.
- R3: A rising edge on `irq_req[i]` sets pending bit i. The bit shows on `pending_vec` after the third clock edge counted from the first edge that samples the input high. The bit stays set after the request drops, and it stays set while the line is disabled.
- R4: An acknowledge (`ack_valid` with `ack_id` = i) sets active bit i and clears pending bit i on the same clock edge. In that cycle the acknowledge clear wins over every set source for line i.
- R5: A return (`ret_valid` with `ret_id` = i) clears active bit i after one clock edge. If an acknowledge and a return name the same line in the same cycle, the line stays active. A return does not clear a pending bit.
- R6: If the synchronized request level of line i is still high when the return for line i is taken, pending bit i is set on that same edge.
- R7: Several request pulses on a line before its acknowledge leave a single pending bit. One acknowledge clears it, and the line does not pend again unless a new edge arrives.
- R8: While a line is active, a request that drops and then rises again sets that line's pending bit.
- R9: `sw_trig_valid` with `sw_trig_id` = i sets pending bit i after one clock edge. This happens whether or not the line is enabled.
- R10: `ready_vec` equals pending AND enable AND NOT active. It is registered, so it changes on the same edge as the state bits.
- R11: After a synchronous reset, all four output vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_LINES | Asynchronous request lines |
| en_set_mask | input | N_LINES | Write-one-to-set mask for enable |
| en_clr_mask | input | N_LINES | Write-one-to-clear mask for enable |
| pend_set_mask | input | N_LINES | Write-one-to-set mask for pending |
| pend_clr_mask | input | N_LINES | Write-one-to-clear mask for pending |
| sw_trig_valid | input | 1 | Software trigger strobe |
| sw_trig_id | input | ID_W | Line number for the software trigger |
| ack_valid | input | 1 | Handler entry strobe |
| ack_id | input | ID_W | Line number entering its handler |
| ret_valid | input | 1 | Handler exit strobe |
| ret_id | input | ID_W | Line number leaving its handler |
| enable_vec | output | N_LINES | Current enable bits |
| pending_vec | output | N_LINES | Current pending bits |
| active_vec | output | N_LINES | Current active bits |
| ready_vec | output | N_LINES | Pending, enabled and not active |

## Verification
The first request pattern is a single short pulse on one line. It shows that the pending latch holds after the request drops. A burst of pulses before the acknowledge shows that several edges merge into one request. A pulse during the handler tells a new edge apart from the old one that the acknowledge already consumed. A level held through the whole handler checks that it re-pends only through the level test at the return, not through a new edge. Directed same-cycle collisions cover set against clear and acknowledge against return. A long random mix of masks, triggers, acknowledges, returns and slowly toggling requests is then compared each cycle against a bench model.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // Per-line set and clear sources gathered in one place.
  typedef struct packed {
    logic rise;
    logic level;
    logic en_set;
    logic en_clr;
    logic pend_set;
    logic pend_clr;
    logic sw_hit;
    logic ack_hit;
    logic ret_hit;
  } line_ctl_t;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int N_LINES = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_async,
  output logic [N_LINES-1:0] req_level,
  output logic [N_LINES-1:0] req_rise
);
  logic [N_LINES-1:0] sync_q [STAGES];
  logic [N_LINES-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= '0;
          else     sync_q[0] <= req_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= '0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign req_level = sync_q[STAGES-1];
  assign req_rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int N_LINES = 32,
  parameter int ID_W    = 5
) (
  input  logic               valid,
  input  logic [ID_W-1:0]    id,
  output logic [N_LINES-1:0] hit
);
  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_dec
      assign hit[i] = valid && (id == ID_W'(i));
    end
  endgenerate

  always_comb begin
    assert ($onehot0(hit)) else $error("a_r9_decode_onehot");
  end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_ctl_t ctl,
  output logic      enable_q,
  output logic      pending_q,
  output logic      active_q,
  output logic      ready_q
);
  logic en_n, pend_n, act_n, pend_sets, pend_clrs;

  always_comb begin
    en_n      = (enable_q | ctl.en_set) & ~ctl.en_clr;
    pend_sets = ctl.rise | ctl.sw_hit | ctl.pend_set | (ctl.ret_hit & ctl.level);
    pend_clrs = ctl.ack_hit | ctl.pend_clr;
    pend_n    = (pending_q | pend_sets) & ~pend_clrs;
    act_n     = (active_q & ~ctl.ret_hit) | ctl.ack_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      enable_q  <= en_n;
      pending_q <= pend_n;
      active_q  <= act_n;
      ready_q   <= pend_n & en_n & ~act_n;
    end
  end

  a_r1_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ctl.en_clr |=> !enable_q);
  a_r1_set_takes: assert property (@(posedge clk) disable iff (rst)
    (ctl.en_set && !ctl.en_clr) |=> enable_q);
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !ctl.ack_hit && !ctl.pend_clr) |=> pending_q);
  a_r4_ack_entry: assert property (@(posedge clk) disable iff (rst)
    ctl.ack_hit |=> (active_q && !pending_q));
  a_r5_ret_exit: assert property (@(posedge clk) disable iff (rst)
    (ctl.ret_hit && !ctl.ack_hit) |=> !active_q);
  a_r6_level_rearm: assert property (@(posedge clk) disable iff (rst)
    (ctl.ret_hit && ctl.level && !ctl.ack_hit && !ctl.pend_clr) |=> pending_q);
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (pending_q && enable_q && !active_q));
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ID_W    = id_width(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_req,
  input  logic [N_LINES-1:0] en_set_mask,
  input  logic [N_LINES-1:0] en_clr_mask,
  input  logic [N_LINES-1:0] pend_set_mask,
  input  logic [N_LINES-1:0] pend_clr_mask,
  input  logic               sw_trig_valid,
  input  logic [ID_W-1:0]    sw_trig_id,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               ret_valid,
  input  logic [ID_W-1:0]    ret_id,
  output logic [N_LINES-1:0] enable_vec,
  output logic [N_LINES-1:0] pending_vec,
  output logic [N_LINES-1:0] active_vec,
  output logic [N_LINES-1:0] ready_vec
);
  logic [N_LINES-1:0] lvl, rise, sw_hit, ack_hit, ret_hit;

  irq_sync_edge #(.N_LINES(N_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .req_async(irq_req),
    .req_level(lvl), .req_rise(rise)
  );

  irq_id_decode #(.N_LINES(N_LINES), .ID_W(ID_W)) u_dec_sw (
    .valid(sw_trig_valid), .id(sw_trig_id), .hit(sw_hit));
  irq_id_decode #(.N_LINES(N_LINES), .ID_W(ID_W)) u_dec_ack (
    .valid(ack_valid), .id(ack_id), .hit(ack_hit));
  irq_id_decode #(.N_LINES(N_LINES), .ID_W(ID_W)) u_dec_ret (
    .valid(ret_valid), .id(ret_id), .hit(ret_hit));

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      line_ctl_t c;
      assign c.rise     = rise[i];
      assign c.level    = lvl[i];
      assign c.en_set   = en_set_mask[i];
      assign c.en_clr   = en_clr_mask[i];
      assign c.pend_set = pend_set_mask[i];
      assign c.pend_clr = pend_clr_mask[i];
      assign c.sw_hit   = sw_hit[i];
      assign c.ack_hit  = ack_hit[i];
      assign c.ret_hit  = ret_hit[i];
      irq_line_state u_line (
        .clk(clk), .rst(rst), .ctl(c),
        .enable_q(enable_vec[i]), .pending_q(pending_vec[i]),
        .active_q(active_vec[i]), .ready_q(ready_vec[i])
      );
    end
  endgenerate

  a_r10_ready_disjoint: assert property (@(posedge clk) disable iff (rst)
    (ready_vec & active_vec) == '0);
  a_r9_sw_pends: assert property (@(posedge clk) disable iff (rst)
    (sw_trig_valid && !ack_valid && (pend_clr_mask == '0)) |=> (pending_vec[$past(sw_trig_id)]));
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (enable_vec == '0 && pending_vec == '0 && active_vec == '0 && ready_vec == '0));
endmodule

// File: tb/irq_pend_tracker_test.sv
module irq_pend_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_req = '0, en_set = '0, en_clr = '0, p_set = '0, p_clr = '0;
  logic sw_v = 0, ack_v = 0, ret_v = 0;
  logic [IW-1:0] sw_id = '0, ack_id = '0, ret_id = '0;
  logic [N-1:0] en_o, pend_o, act_o, rdy_o;

  // bench model
  logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_pend, m_act, m_rdy;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_tracker #(.N_LINES(N)) uut (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .en_set_mask(en_set), .en_clr_mask(en_clr),
    .pend_set_mask(p_set), .pend_clr_mask(p_clr),
    .sw_trig_valid(sw_v), .sw_trig_id(sw_id),
    .ack_valid(ack_v), .ack_id(ack_id),
    .ret_valid(ret_v), .ret_id(ret_id),
    .enable_vec(en_o), .pending_vec(pend_o),
    .active_vec(act_o), .ready_vec(rdy_o)
  );

  function automatic logic [N-1:0] onehot(input logic v, input logic [IW-1:0] id);
    return v ? (N'(1) << id) : '0;
  endfunction

  task automatic model_step();
    logic [N-1:0] rise, lvl, a, r, t;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_en = '0; m_pend = '0; m_act = '0; m_rdy = '0;
    end else begin
      rise = m_s2 & ~m_s3; lvl = m_s2;
      a = onehot(ack_v, ack_id); r = onehot(ret_v, ret_id); t = onehot(sw_v, sw_id);
      m_en   = (m_en | en_set) & ~en_clr;
      m_pend = (m_pend | rise | t | p_set | (r & lvl)) & ~(a | p_clr);
      m_act  = (m_act & ~r) | a;
      m_rdy  = m_pend & m_en & ~m_act;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_req;
    end
  endtask

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " enable"},  en_o,   m_en);
    chk({tag, " pending"}, pend_o, m_pend);
    chk({tag, " active"},  act_o,  m_act);
    chk({tag, " R10 ready"}, rdy_o, m_rdy);
  endtask

  // one clock: inputs already set at negedge, one-shots cleared afterwards
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    en_set = '0; en_clr = '0; p_set = '0; p_clr = '0;
    sw_v = 0; ack_v = 0; ret_v = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    chk("R11 reset enable", en_o, '0);
    chk("R11 reset pending", pend_o, '0);
    chk("R11 reset active", act_o, '0);
    chk("R11 reset ready", rdy_o, '0);

    // R1
    en_set = 32'h0000_00F0; tick();
    chk("R1 set", en_o, 32'h0000_00F0);
    en_clr = 32'h0000_0030; en_set = 32'h0000_0001; tick();
    chk("R1 clear and zero bits", en_o, 32'h0000_00C1);
    en_set = 32'h0000_0002; en_clr = 32'h0000_0002; tick();
    chk("R1 clear wins", en_o, 32'h0000_00C1);
    en_set = 32'h0000_00FC; tick();  // enable lines 2..7

    // R2 / R10
    p_set = 32'h0000_0004; tick();
    chk("R2 pend set", pend_o, 32'h0000_0004);
    chk("R10 ready", rdy_o, 32'h0000_0004);
    p_set = 32'h0000_0008; p_clr = 32'h0000_000C; tick();
    chk("R2 clear wins", pend_o, '0);

    // R3: single short pulse on line 5
    irq_req[5] = 1; tick(); irq_req[5] = 0; tick();
    chk("R3 not yet", pend_o, '0);
    tick();
    chk("R3 latched after drop", pend_o, 32'h0000_0020);
    // R7: more pulses while pending
    repeat (3) begin irq_req[5] = 1; tick(); tick(); irq_req[5] = 0; tick(); tick(); end
    chk("R7 still one", pend_o, 32'h0000_0020);
    ack_v = 1; ack_id = 5; tick();
    chk("R4 ack pending", pend_o, '0);
    chk("R4 ack active", act_o, 32'h0000_0020);
    repeat (4) tick();
    chk("R7 no re-pend", pend_o, '0);
    // R8: pulse during handler
    irq_req[5] = 1; tick(); irq_req[5] = 0; repeat (3) tick();
    chk("R8 re-pend", pend_o, 32'h0000_0020);
    chk("R10 active excluded", rdy_o, '0);
    ret_v = 1; ret_id = 5; tick();
    chk("R5 ret clears active", act_o, '0);
    chk("R5 ret keeps pending", pend_o, 32'h0000_0020);
    chk("R10 ready after ret", rdy_o, 32'h0000_0020);
    ack_v = 1; ack_id = 5; tick(); ret_v = 1; ret_id = 5; tick();

    // R6: level held through handler on line 6
    irq_req[6] = 1; repeat (3) tick();
    chk("R6 pend by edge", pend_o, 32'h0000_0040);
    ack_v = 1; ack_id = 6; tick(); repeat (3) tick();
    chk("R6 held no edge", pend_o, '0);
    ret_v = 1; ret_id = 6; tick();
    chk("R6 re-pend at return", pend_o, 32'h0000_0040);
    chk("R6 active cleared", act_o, '0);
    irq_req[6] = 0; p_clr = 32'h0000_0040; repeat (3) tick();

    // R4 clear beats set; R5 ack beats ret
    p_set = 32'h0000_0080; ack_v = 1; ack_id = 7; tick();
    chk("R4 ack over set pending", pend_o, '0);
    chk("R4 ack over set active", act_o, 32'h0000_0080);
    ret_v = 1; ret_id = 7; ack_v = 1; ack_id = 7; tick();
    chk("R5 ack and ret same line", act_o, 32'h0000_0080);
    ret_v = 1; ret_id = 7; tick();
    chk("R5 ret alone", act_o, '0);

    // R9: software trigger on a disabled line
    sw_v = 1; sw_id = 31; tick();
    chk("R9 sw trigger", pend_o, 32'h8000_0000);
    chk("R9 disabled not ready", rdy_o, '0);
    chk_model("R9 model");

    // random mix against the model
    for (int k = 0; k < 3000; k++) begin
      for (int b = 0; b < N; b++) if ($urandom_range(0, 15) == 0) irq_req[b] = ~irq_req[b];
      if ($urandom_range(0, 7) == 0) en_set = $urandom() & $urandom();
      if ($urandom_range(0, 7) == 0) en_clr = $urandom() & $urandom();
      if ($urandom_range(0, 9) == 0) p_set = $urandom() & $urandom();
      if ($urandom_range(0, 9) == 0) p_clr = $urandom() & $urandom();
      sw_v = ($urandom_range(0, 5) == 0); sw_id = IW'($urandom());
      ack_v = ($urandom_range(0, 3) == 0); ack_id = IW'($urandom_range(0, 7));
      ret_v = ($urandom_range(0, 3) == 0); ret_id = IW'($urandom_range(0, 7));
      tick();
      chk_model("R3 R4 R5 R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule